// File: doc/BRIEF.md
# Programmable Divided Countdown Timer

This block is a 32-bit down-counter whose decrement rate is the core clock divided by a programmable power of two. Software-style register writes arrive over a single-cycle write strobe with a select code and a 32-bit data word. Three registers are reachable: a divider setting, a start value, and a timer entry that carries an interrupt vector, a suppress bit and a repeat-mode bit.

Writing the start value loads the counter and restarts the division phase. Each divided tick moves the count one step down. In single-run mode the count parks at zero. In repeat mode the tick after zero restores the start value, so a run of N+1 ticks forms one period. The tick that moves the count from one to zero is the expiry. Unless suppressed, the expiry raises a one-cycle request, and the vector of the entry is presented beside it. Delivering that vector to an interrupt controller is left to the surrounding logic.

Top module: `divtimer_top`

## Requirements
- R1: After reset the count reads 0 and no request is raised. The entry reads vector 0, suppressed, single-run. The divider setting is 0, which divides by 2.
- R2: Only data bits 3, 1 and 0 of a divider write are kept. The code {bit3,bit1,bit0} gives a shift of (code+1) mod 8, and one tick occurs every 2^shift clocks. Code 7 divides by 1, code 0 by 2 and code 4 by 32.
- R3: A start-value write shows on the count in the next cycle and restarts the division phase. The first decrement comes 2^shift clocks after the loading edge.
- R4: In single-run mode (entry bit 17 = 0) each tick lowers a nonzero count by one, and a zero count stays at zero.
- R5: In repeat mode (entry bit 17 = 1) a tick at count zero reloads the stored start value.
- R6: The tick that takes the count from 1 to 0 sets `irqPulse` high for one cycle, the cycle in which the count first reads 0. `irqVector` always shows entry bits 7:0.
- R7: While entry bit 16 is set, no request is raised, and counting goes on unchanged.
- R8: An entry write takes effect from the next tick on. A single-run counter parked at zero that is switched to repeat mode reloads on the following tick.
- R9: A start value of 0 keeps the count at 0 and never raises a request, in either mode.
- R10: Select codes are 0 = divider, 1 = start value and 2 = entry. A write with select 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| wrSel | input | 2 | Register select (0 divider, 1 start value, 2 entry, 3 none) |
| wrData | input | 32 | Write data |
| curCount | output | 32 | Current count |
| irqPulse | output | 1 | One-cycle expiry request |
| irqVector | output | 8 | Vector sent with the request |

## Verification
The checker assumes each write strobe lasts one cycle with stable select and data. It also tracks the suppress bit only through entry writes seen at the ports. It expects the count to change only by a single step down, by a reload out of zero, or by a start-value write. The stimulus drives every write for exactly one clock away from the active edge. Between writes it idles long enough that the divided ticks, the expiries and the repeat-mode reloads can be observed.

// File: rtl/divtimer_pkg.sv
package divtimer_pkg;
  localparam logic [1:0] SEL_DIV   = 2'd0;
  localparam logic [1:0] SEL_START = 2'd1;
  localparam logic [1:0] SEL_ENTRY = 2'd2;
  localparam int MASK_BIT   = 16;
  localparam int REPEAT_BIT = 17;
  localparam int CODE_W     = 3;

  typedef struct packed {
    logic load;
    logic tick;
    logic repeatMode;
    logic masked;
  } tmrStrobe_t;
endpackage

// File: rtl/divtimer_ctrl.sv
module divtimer_ctrl
  import divtimer_pkg::*;
#(
  parameter int COUNT_W = 32,
  parameter int VEC_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [1:0]         wrSel,
  input  logic [31:0]        wrData,
  output tmrStrobe_t         strb,
  output logic [COUNT_W-1:0] loadVal,
  output logic [COUNT_W-1:0] startVal,
  output logic [VEC_W-1:0]   vecOut
);
  localparam int PRE_W = (1 << CODE_W) - 1;

  logic [3:0]        divCfg;
  logic [CODE_W-1:0] shiftAmt;
  logic [PRE_W-1:0]  preCnt;
  logic [PRE_W-1:0]  tickMask;
  logic              maskBit;
  logic              repeatBit;
  logic              startWr;

  assign startWr = wrEn && (wrSel == SEL_START);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCfg    <= '0;
      startVal  <= '0;
      vecOut    <= '0;
      maskBit   <= 1'b1;
      repeatBit <= 1'b0;
    end else if (wrEn) begin
      case (wrSel)
        SEL_DIV:   divCfg <= wrData[3:0] & 4'hB;
        SEL_START: startVal <= wrData[COUNT_W-1:0];
        SEL_ENTRY: begin
          vecOut    <= wrData[VEC_W-1:0];
          maskBit   <= wrData[MASK_BIT];
          repeatBit <= wrData[REPEAT_BIT];
        end
        default: ;
      endcase
    end
  end

  assign shiftAmt = {divCfg[3], divCfg[1:0]} + CODE_W'(1);
  assign tickMask = (PRE_W'(1) << shiftAmt) - PRE_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        preCnt <= '0;
    else if (startWr) preCnt <= '0;
    else              preCnt <= preCnt + PRE_W'(1);
  end

  always_comb begin
    strb.load       = startWr;
    strb.tick       = ((preCnt & tickMask) == tickMask);
    strb.repeatMode = repeatBit;
    strb.masked     = maskBit;
  end

  assign loadVal = wrData[COUNT_W-1:0];
endmodule

// File: rtl/divtimer_datapath.sv
module divtimer_datapath
  import divtimer_pkg::*;
#(
  parameter int COUNT_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  tmrStrobe_t         strb,
  input  logic [COUNT_W-1:0] loadVal,
  input  logic [COUNT_W-1:0] startVal,
  output logic [COUNT_W-1:0] count,
  output logic               expiry
);
  localparam logic [COUNT_W-1:0] ONE = COUNT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count  <= '0;
      expiry <= 1'b0;
    end else begin
      expiry <= 1'b0;
      if (strb.load) begin
        count <= loadVal;
      end else if (strb.tick) begin
        if (count > ONE) begin
          count <= count - ONE;
        end else if (count == ONE) begin
          count  <= '0;
          expiry <= !strb.masked;
        end else if (strb.repeatMode) begin
          count <= startVal;
        end
      end
    end
  end
endmodule

// File: rtl/divtimer_top.sv
module divtimer_top
  import divtimer_pkg::*;
#(
  parameter int COUNT_W = 32,
  parameter int VEC_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [1:0]         wrSel,
  input  logic [31:0]        wrData,
  output logic [COUNT_W-1:0] curCount,
  output logic               irqPulse,
  output logic [VEC_W-1:0]   irqVector
);
  tmrStrobe_t         strb;
  logic [COUNT_W-1:0] loadVal;
  logic [COUNT_W-1:0] startVal;

  divtimer_ctrl #(.COUNT_W(COUNT_W), .VEC_W(VEC_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .strb(strb), .loadVal(loadVal), .startVal(startVal), .vecOut(irqVector)
  );

  divtimer_datapath #(.COUNT_W(COUNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .loadVal(loadVal),
    .startVal(startVal), .count(curCount), .expiry(irqPulse)
  );
endmodule

// File: rtl/divtimer_chk.sv
module divtimer_chk
  import divtimer_pkg::*;
#(
  parameter int COUNT_W = 32,
  parameter int VEC_W   = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [1:0]         wrSel,
  input logic [31:0]        wrData,
  input logic [COUNT_W-1:0] curCount,
  input logic               irqPulse,
  input logic [VEC_W-1:0]   irqVector
);
  logic maskShadow;
  logic startWr;
  assign startWr = wrEn && (wrSel == SEL_START);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) maskShadow <= 1'b1;
    else if (wrEn && wrSel == SEL_ENTRY) maskShadow <= wrData[MASK_BIT];
  end

  // R3: a start-value write appears on the count one cycle later
  assert_start_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    startWr |=> (curCount == $past(wrData[COUNT_W-1:0])));

  // R4 / R5: without a load, the count only steps down by one or leaves zero
  assert_single_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(startWr) && curCount != $past(curCount)) |->
      (curCount == $past(curCount) - COUNT_W'(1) || $past(curCount) == '0));

  // R6: the request coincides with a zero count
  assert_irq_at_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> (curCount == '0));

  // R6: the request lasts a single cycle
  assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);

  // R7: no request while the suppress bit was set
  assert_mask_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> !$past(maskShadow));
endmodule

bind divtimer_top divtimer_chk #(.COUNT_W(COUNT_W), .VEC_W(VEC_W)) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
  .curCount(curCount), .irqPulse(irqPulse), .irqVector(irqVector)
);

// File: tb/divtimer_tb.sv
module divtimer_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = '0;
  logic [31:0] wrData = '0;
  logic [31:0] curCount;
  logic        irqPulse;
  logic [7:0]  irqVector;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;
  string curReq = "R1";

  // reference model state
  longint mCnt = 0, mInit = 0;
  int     mK = 0, mShift = 1, mVec = 0;
  bit     mPer = 0, mMask = 1, mIrq = 0;
  bit     tk;
  int     code;

  always #(CLK_PERIOD/2) clk = ~clk;

  divtimer_top dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .curCount(curCount), .irqPulse(irqPulse), .irqVector(irqVector)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mInit = 0; mK = 0; mShift = 1; mVec = 0;
      mPer = 0; mMask = 1; mIrq = 0;
    end else begin
      tk = (((mK + 1) % (1 << mShift)) == 0);
      mIrq = 0;
      if (wrEn && wrSel == 2'd1) begin
        mCnt = wrData; mK = 0;
      end else begin
        mK = mK + 1;
        if (tk) begin
          if (mCnt > 1) mCnt = mCnt - 1;
          else if (mCnt == 1) begin mCnt = 0; mIrq = !mMask; end
          else if (mPer) mCnt = mInit;
        end
      end
      if (wrEn) begin
        if (wrSel == 2'd0) begin
          code = {wrData[3], wrData[1], wrData[0]};
          mShift = (code + 1) % 8;
        end else if (wrSel == 2'd1) mInit = wrData;
        else if (wrSel == 2'd2) begin
          mVec = wrData[7:0]; mMask = wrData[16]; mPer = wrData[17];
        end
      end
    end
  end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(curReq, "model count", curCount, mCnt);
      check(curReq, "model irq", irqPulse, mIrq);
      check(curReq, "model vector", irqVector, mVec);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0; wrSel = '0; wrData = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle(1);
    // R1 reset state
    check("R1", "reset count", curCount, 0);
    check("R1", "reset irq", irqPulse, 0);
    check("R1", "reset vector", irqVector, 0);
    // R1 default divide by 2, R3 restart
    curReq = "R3";
    wr(2'd1, 32'd10);
    check("R3", "load", curCount, 10);
    idle(4);
    check("R1", "default div2", curCount, 8);
    idle(1);
    wr(2'd1, 32'd10);
    idle(1);
    check("R3", "phase restart", curCount, 10);
    idle(1);
    check("R3", "first tick", curCount, 9);
    // R2 divider codes
    curReq = "R2";
    wr(2'd0, 32'h0000_000F);
    wr(2'd1, 32'd20);
    idle(5);
    check("R2", "code7 div1", curCount, 15);
    wr(2'd0, 32'h0000_0004);
    wr(2'd1, 32'd20);
    idle(6);
    check("R2", "bit2 ignored div2", curCount, 17);
    wr(2'd0, 32'h0000_0008);
    wr(2'd1, 32'd5);
    idle(64);
    check("R2", "code4 div32", curCount, 3);
    // R4 single-run and R6 expiry
    curReq = "R4";
    wr(2'd0, 32'h0000_000B);
    wr(2'd2, 32'h0000_0042);
    wr(2'd1, 32'd3);
    idle(3);
    check("R4", "reach zero", curCount, 0);
    check("R6", "expiry pulse", irqPulse, 1);
    check("R6", "vector", irqVector, 8'h42);
    idle(1);
    check("R6", "pulse one cycle", irqPulse, 0);
    idle(5);
    check("R4", "hold zero", curCount, 0);
    // R8 switch parked counter to repeat mode
    curReq = "R8";
    wr(2'd2, 32'h0002_0042);
    check("R8", "no reload same edge", curCount, 0);
    idle(1);
    check("R8", "reload next tick", curCount, 3);
    // R5 repeat mode
    curReq = "R5";
    wr(2'd2, 32'h0002_0055);
    wr(2'd1, 32'd2);
    idle(2);
    check("R5", "zero", curCount, 0);
    check("R6", "repeat pulse", irqPulse, 1);
    idle(1);
    check("R5", "wrap", curCount, 2);
    idle(8);
    // R7 suppressed
    curReq = "R7";
    wr(2'd2, 32'h0003_0077);
    wr(2'd1, 32'd1);
    idle(1);
    check("R7", "count zero", curCount, 0);
    check("R7", "no pulse", irqPulse, 0);
    idle(1);
    check("R7", "still counting", curCount, 1);
    idle(10);
    // R9 start value zero
    curReq = "R9";
    wr(2'd2, 32'h0002_0011);
    wr(2'd1, 32'd0);
    idle(20);
    check("R9", "stopped", curCount, 0);
    check("R9", "no pulse", irqPulse, 0);
    // R10 unused select
    curReq = "R10";
    wr(2'd3, 32'hFFFF_FFFF);
    idle(3);
    check("R10", "vector kept", irqVector, 8'h11);
    check("R10", "count kept", curCount, 0);
    wr(2'd1, 32'd4);
    idle(4);
    check("R10", "no mask or divider change", curCount, 0);
    idle(2);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule